// File: doc/BRIEF.md
# File-command control register bank

This block sits between a processor's memory-mapped bus and a hardware file-system storage engine paired with a test-data generator. The processor writes the operating parameters into holding registers: the starting file name, the number of files, a file-size code, a packed creation timestamp, a data-pattern selector and a reset bit for the test logic. The block drives these values to the engine continuously.

A write to the command offset stores a two-bit operation code and sends the engine a one-cycle start pulse. If the engine reports busy, the command write is refused. The timestamp word uses the FAT date/time packing. The block also splits it into separate field outputs so that the engine does not need to decode it again.

On the read side, the processor sees a registered mux over the engine's status. This covers the busy, error and verify-failure flags, the file capacity and the error type. It also covers the test generator's failure record (file offset, file name, expected and received data words) and the running byte count of the transfer.

Top module: `fcmd_regbank`

## Requirements
- R1: While reset is high and in the first cycle after it is released, every writable register output, `start_o`, `trst_o`, `rvalid` and `rdata` are zero.
- R2: A write to offset 0x000 (name, bits [15:0]), 0x004 (count, bits [15:0]), 0x008 (size code, bits [2:0]) or 0x014 (pattern, bits [2:0]) updates the matching output on the clock edge that samples the write. Higher data bits are discarded.
- R3: A write to offset 0x00C stores the 32-bit timestamp. The field outputs then follow it: seconds from bits [4:0], minutes from [10:5], hours from [15:11], day from [20:16], month from [24:21] and year from [31:25].
- R4: A write to offset 0x010 with `busy_i` low stores bits [1:0] as the command (00 format, 10 write files, 11 read files). It raises `start_o` for exactly the one cycle after the write edge.
- R5: A write to offset 0x010 with `busy_i` high is ignored: `start_o` stays low and `cmd_o` keeps its value.
- R6: Bit 0 of a write to offset 0x01C drives `trst_o`: 1 holds the test logic in reset and 0 releases it.
- R7: A read of offset 0x100 returns busy in bit 0, engine error in bit 1 and verify failure in bit 2, with all other bits zero.
- R8: A read of 0x104 returns the 16-bit capacity zero-extended, and a read of 0x108 returns the 32-bit error type.
- R9: A read of 0x180 returns the failure byte offset and 0x184 returns the failure file name (zero-extended). 0x188, 0x18C, 0x190 and 0x194 return expected data words 0 to 3 (word 0 holds bits [31:0]). 0x198 to 0x1A4 return received words 0 to 3 in the same order. 0x1A8 returns byte count bits [31:0] and 0x1AC returns bits [39:32] zero-extended.
- R10: `rvalid` is high in exactly the cycle after each read strobe, and `rdata` then holds the value selected at the strobe.
- R11: Reads of any other offset, including the write-only and misaligned ones, return zero. Writes to any offset not listed above leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| rvalid | output | 1 | Read data valid |
| busy_i | input | 1 | Engine busy |
| err_i | input | 1 | Engine error |
| vfail_i | input | 1 | Data verify failure |
| cap_i | input | 16 | Total file capacity |
| etype_i | input | 32 | Engine error type |
| faddr_i | input | 32 | Failing byte offset within file |
| ffname_i | input | 16 | Failing file name |
| exp_i | input | 128 | Expected data at failure |
| got_i | input | 128 | Received data at failure |
| xfer_i | input | 40 | Transferred byte count |
| fname_o | output | 16 | Starting file name |
| count_o | output | 16 | Number of files |
| size_o | output | 3 | File-size code |
| stamp_o | output | 32 | Packed creation timestamp |
| sec_o | output | 5 | Timestamp seconds field |
| min_o | output | 6 | Timestamp minutes field |
| hour_o | output | 5 | Timestamp hours field |
| day_o | output | 5 | Timestamp day field |
| mon_o | output | 4 | Timestamp month field |
| year_o | output | 7 | Timestamp year field |
| cmd_o | output | 2 | Operation code |
| start_o | output | 1 | One-cycle start request |
| pat_o | output | 3 | Pattern select |
| trst_o | output | 1 | Test logic reset |

## Verification
The assertions run on every cycle. They check that each start pulse comes from an accepted command write, that a command write during busy changes nothing, that `rvalid` follows the read strobe by one cycle, and that the status word and unmapped reads return the values they should.

Some behaviour only the bench scenarios can show. These are the masking of wide write data, the position of each timestamp field, the mapping of every read offset with random engine values, and the fact that writes to unmapped or read-only offsets leave all outputs untouched.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  localparam int OFF_W = 12;
  typedef logic [OFF_W-1:0] off_t;

  localparam off_t OFF_NAME  = 12'h000;
  localparam off_t OFF_COUNT = 12'h004;
  localparam off_t OFF_SIZE  = 12'h008;
  localparam off_t OFF_STAMP = 12'h00C;
  localparam off_t OFF_CMD   = 12'h010;
  localparam off_t OFF_PAT   = 12'h014;
  localparam off_t OFF_TRST  = 12'h01C;
  localparam off_t OFF_STAT  = 12'h100;
  localparam off_t OFF_CAP   = 12'h104;
  localparam off_t OFF_ETYPE = 12'h108;
  localparam off_t OFF_FADDR = 12'h180;
  localparam off_t OFF_FNAME = 12'h184;
  localparam off_t OFF_EXP0  = 12'h188;

  typedef enum logic [1:0] {
    CMD_FORMAT = 2'b00,
    CMD_RSVD   = 2'b01,
    CMD_WRITE  = 2'b10,
    CMD_READ   = 2'b11
  } cmd_e;

  typedef struct packed {
    logic [6:0] year;
    logic [3:0] month;
    logic [4:0] day;
    logic [4:0] hour;
    logic [5:0] minute;
    logic [4:0] second;
  } stamp_t;
endpackage

// File: rtl/fcr_wr_side.sv
module fcr_wr_side
  import fcr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NAME_W = 16,
  parameter int CNT_W  = 16,
  parameter int SIZE_W = 3,
  parameter int PAT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              busy_i,
  output logic [NAME_W-1:0] fname_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [SIZE_W-1:0] size_o,
  output logic [31:0]       stamp_o,
  output logic [1:0]        cmd_o,
  output logic              start_o,
  output logic [PAT_W-1:0]  pat_o,
  output logic              trst_o
);
  localparam logic [ADDR_W-1:0] A_NAME  = ADDR_W'(OFF_NAME);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFF_COUNT);
  localparam logic [ADDR_W-1:0] A_SIZE  = ADDR_W'(OFF_SIZE);
  localparam logic [ADDR_W-1:0] A_STAMP = ADDR_W'(OFF_STAMP);
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFF_CMD);
  localparam logic [ADDR_W-1:0] A_PAT   = ADDR_W'(OFF_PAT);
  localparam logic [ADDR_W-1:0] A_TRST  = ADDR_W'(OFF_TRST);

  cmd_e cmd_q;
  assign cmd_o = cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fname_o <= '0;
      count_o <= '0;
      size_o  <= '0;
      stamp_o <= '0;
      cmd_q   <= CMD_FORMAT;
      start_o <= 1'b0;
      pat_o   <= '0;
      trst_o  <= 1'b0;
    end else begin
      start_o <= 1'b0;
      if (wr_en) begin
        case (addr)
          A_NAME:  fname_o <= wdata[NAME_W-1:0];
          A_COUNT: count_o <= wdata[CNT_W-1:0];
          A_SIZE:  size_o  <= wdata[SIZE_W-1:0];
          A_STAMP: stamp_o <= wdata;
          A_CMD: begin
            if (!busy_i) begin
              cmd_q   <= cmd_e'(wdata[1:0]);
              start_o <= 1'b1;
            end
          end
          A_PAT:   pat_o  <= wdata[PAT_W-1:0];
          A_TRST:  trst_o <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  AST_START_CAUSE: assert property (@(posedge clk) disable iff (rst)
    start_o |-> $past(wr_en && addr == A_CMD && !busy_i)); // R4
  AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CMD && busy_i) |=> (!start_o && $stable(cmd_o))); // R5
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == A_CMD) |=> $stable(cmd_o)); // R11
endmodule

// File: rtl/fcr_rd_side.sv
module fcr_rd_side
  import fcr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CAP_W  = 16,
  parameter int NAME_W = 16,
  parameter int LANES  = 4,
  parameter int XFER_W = 40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                busy_i,
  input  logic                err_i,
  input  logic                vfail_i,
  input  logic [CAP_W-1:0]    cap_i,
  input  logic [31:0]         etype_i,
  input  logic [31:0]         faddr_i,
  input  logic [NAME_W-1:0]   ffname_i,
  input  logic [LANES*32-1:0] exp_i,
  input  logic [LANES*32-1:0] got_i,
  input  logic [XFER_W-1:0]   xfer_i,
  output logic [31:0]         rdata_o,
  output logic                rvalid_o
);
  localparam int GOT_BASE  = int'(OFF_EXP0) + 4 * LANES;
  localparam int XFER_BASE = GOT_BASE + 4 * LANES;
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_CAP   = ADDR_W'(OFF_CAP);
  localparam logic [ADDR_W-1:0] A_ETYPE = ADDR_W'(OFF_ETYPE);
  localparam logic [ADDR_W-1:0] A_FADDR = ADDR_W'(OFF_FADDR);
  localparam logic [ADDR_W-1:0] A_FNAME = ADDR_W'(OFF_FNAME);
  localparam logic [ADDR_W-1:0] A_XLO   = ADDR_W'(XFER_BASE);
  localparam logic [ADDR_W-1:0] A_XHI   = ADDR_W'(XFER_BASE + 4);

  logic [LANES-1:0] exp_hit, got_hit;
  logic [31:0]      exp_w [LANES];
  logic [31:0]      got_w [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign exp_hit[g] = (addr == ADDR_W'(int'(OFF_EXP0) + 4 * g));
    assign got_hit[g] = (addr == ADDR_W'(GOT_BASE + 4 * g));
    assign exp_w[g]   = exp_i[32*g +: 32];
    assign got_w[g]   = got_i[32*g +: 32];
  end

  logic [31:0] sel;
  logic        scalar_hit;

  always_comb begin
    sel        = '0;
    scalar_hit = 1'b1;
    case (addr)
      A_STAT:  sel = {29'b0, vfail_i, err_i, busy_i};
      A_CAP:   sel = 32'(cap_i);
      A_ETYPE: sel = etype_i;
      A_FADDR: sel = faddr_i;
      A_FNAME: sel = 32'(ffname_i);
      A_XLO:   sel = xfer_i[31:0];
      A_XHI:   sel = 32'(xfer_i[XFER_W-1:32]);
      default: scalar_hit = 1'b0;
    endcase
    for (int i = 0; i < LANES; i++) begin
      if (exp_hit[i]) sel = exp_w[i];
      if (got_hit[i]) sel = got_w[i];
    end
  end

  logic any_hit;
  assign any_hit = scalar_hit || (|exp_hit) || (|got_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en;
      if (rd_en) rdata_o <= sel;
    end
  end

  AST_RVALID_LAT: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid_o); // R10
  AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rvalid_o); // R10
  AST_STATUS_BITS: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_STAT) |=>
      rdata_o == {29'b0, $past(vfail_i), $past(err_i), $past(busy_i)}); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !any_hit) |=> rdata_o == 32'b0); // R11
endmodule

// File: rtl/fcmd_regbank.sv
module fcmd_regbank
  import fcr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NAME_W = 16,
  parameter int CNT_W  = 16,
  parameter int SIZE_W = 3,
  parameter int PAT_W  = 3,
  parameter int CAP_W  = 16,
  parameter int LANES  = 4,
  parameter int XFER_W = 40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  output logic                rvalid,
  input  logic                busy_i,
  input  logic                err_i,
  input  logic                vfail_i,
  input  logic [CAP_W-1:0]    cap_i,
  input  logic [31:0]         etype_i,
  input  logic [31:0]         faddr_i,
  input  logic [NAME_W-1:0]   ffname_i,
  input  logic [LANES*32-1:0] exp_i,
  input  logic [LANES*32-1:0] got_i,
  input  logic [XFER_W-1:0]   xfer_i,
  output logic [NAME_W-1:0]   fname_o,
  output logic [CNT_W-1:0]    count_o,
  output logic [SIZE_W-1:0]   size_o,
  output logic [31:0]         stamp_o,
  output logic [4:0]          sec_o,
  output logic [5:0]          min_o,
  output logic [4:0]          hour_o,
  output logic [4:0]          day_o,
  output logic [3:0]          mon_o,
  output logic [6:0]          year_o,
  output logic [1:0]          cmd_o,
  output logic                start_o,
  output logic [PAT_W-1:0]    pat_o,
  output logic                trst_o
);
  fcr_wr_side #(
    .ADDR_W(ADDR_W), .NAME_W(NAME_W), .CNT_W(CNT_W),
    .SIZE_W(SIZE_W), .PAT_W(PAT_W)
  ) i_wr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .busy_i(busy_i), .fname_o(fname_o), .count_o(count_o), .size_o(size_o),
    .stamp_o(stamp_o), .cmd_o(cmd_o), .start_o(start_o), .pat_o(pat_o),
    .trst_o(trst_o)
  );

  fcr_rd_side #(
    .ADDR_W(ADDR_W), .CAP_W(CAP_W), .NAME_W(NAME_W),
    .LANES(LANES), .XFER_W(XFER_W)
  ) i_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .busy_i(busy_i),
    .err_i(err_i), .vfail_i(vfail_i), .cap_i(cap_i), .etype_i(etype_i),
    .faddr_i(faddr_i), .ffname_i(ffname_i), .exp_i(exp_i), .got_i(got_i),
    .xfer_i(xfer_i), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  stamp_t stamp_v;
  assign stamp_v = stamp_t'(stamp_o);
  assign sec_o   = stamp_v.second;
  assign min_o   = stamp_v.minute;
  assign hour_o  = stamp_v.hour;
  assign day_o   = stamp_v.day;
  assign mon_o   = stamp_v.month;
  assign year_o  = stamp_v.year;

  AST_START_SPACED: assert property (@(posedge clk) disable iff (rst)
    (start_o && !(wr_en && addr == ADDR_W'(OFF_CMD))) |=> !start_o); // R4
endmodule

// File: tb/test_fcmd_regbank.sv
`timescale 1ns/1ps
module test_fcmd_regbank;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, wr_en, rd_en, busy_i, err_i, vfail_i, rvalid, start_o, trst_o;
  logic [11:0] addr;
  logic [31:0] wdata, rdata, etype_i, faddr_i, stamp_o;
  logic [15:0] cap_i, ffname_i, fname_o, count_o;
  logic [127:0] exp_i, got_i;
  logic [39:0] xfer_i;
  logic [2:0] size_o, pat_o;
  logic [1:0] cmd_o;
  logic [4:0] sec_o, hour_o, day_o;
  logic [5:0] min_o;
  logic [3:0] mon_o;
  logic [6:0] year_o;

  fcmd_regbank i_fcmd_regbank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .busy_i(busy_i),
    .err_i(err_i), .vfail_i(vfail_i), .cap_i(cap_i), .etype_i(etype_i),
    .faddr_i(faddr_i), .ffname_i(ffname_i), .exp_i(exp_i), .got_i(got_i),
    .xfer_i(xfer_i), .fname_o(fname_o), .count_o(count_o), .size_o(size_o),
    .stamp_o(stamp_o), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .day_o(day_o), .mon_o(mon_o), .year_o(year_o), .cmd_o(cmd_o),
    .start_o(start_o), .pat_o(pat_o), .trst_o(trst_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [15:0] m_fname, m_count;
  logic [2:0]  m_size, m_pat;
  logic [31:0] m_stamp;
  logic [1:0]  m_cmd;
  logic        m_trst;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_outs(string req);
    chk({req, " name"},  64'(fname_o), 64'(m_fname));
    chk({req, " count"}, 64'(count_o), 64'(m_count));
    chk({req, " size"},  64'(size_o),  64'(m_size));
    chk({req, " pat"},   64'(pat_o),   64'(m_pat));
    chk({req, " stamp"}, 64'(stamp_o), 64'(m_stamp));
    chk({req, " cmd"},   64'(cmd_o),   64'(m_cmd));
    chk({req, " trst"},  64'(trst_o),  64'(m_trst));
    chk("R3 sec",  64'(sec_o),  64'(m_stamp[4:0]));
    chk("R3 min",  64'(min_o),  64'(m_stamp[10:5]));
    chk("R3 hour", 64'(hour_o), 64'(m_stamp[15:11]));
    chk("R3 day",  64'(day_o),  64'(m_stamp[20:16]));
    chk("R3 mon",  64'(mon_o),  64'(m_stamp[24:21]));
    chk("R3 year", 64'(year_o), 64'(m_stamp[31:25]));
  endtask

  function automatic logic [31:0] exp_rd(logic [11:0] a);
    case (a)
      12'h100: return {29'b0, vfail_i, err_i, busy_i};
      12'h104: return {16'b0, cap_i};
      12'h108: return etype_i;
      12'h180: return faddr_i;
      12'h184: return {16'b0, ffname_i};
      12'h188: return exp_i[31:0];
      12'h18C: return exp_i[63:32];
      12'h190: return exp_i[95:64];
      12'h194: return exp_i[127:96];
      12'h198: return got_i[31:0];
      12'h19C: return got_i[63:32];
      12'h1A0: return got_i[95:64];
      12'h1A4: return got_i[127:96];
      12'h1A8: return xfer_i[31:0];
      12'h1AC: return {24'b0, xfer_i[39:32]};
      default: return 32'b0;
    endcase
  endfunction

  task automatic wr(string req, logic [11:0] a, logic [31:0] d);
    logic exp_start;
    exp_start = 1'b0;
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    case (a)
      12'h000: m_fname = d[15:0];
      12'h004: m_count = d[15:0];
      12'h008: m_size  = d[2:0];
      12'h00C: m_stamp = d;
      12'h010: if (!busy_i) begin m_cmd = d[1:0]; exp_start = 1'b1; end
      12'h014: m_pat   = d[2:0];
      12'h01C: m_trst  = d[0];
      default: ;
    endcase
    @(negedge clk);
    wr_en = 1'b0;
    chk({req, " start"}, 64'(start_o), 64'(exp_start));
    check_outs(req);
    @(negedge clk);
    chk({req, " start drop"}, 64'(start_o), 64'd0);
  endtask

  task automatic rd(string req, logic [11:0] a);
    logic [31:0] e;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    e = exp_rd(a);
    @(negedge clk);
    rd_en = 1'b0;
    chk("R10 rvalid", 64'(rvalid), 64'd1);
    chk(req, 64'(rdata), 64'(e));
    @(negedge clk);
    chk("R10 rvalid drop", 64'(rvalid), 64'd0);
  endtask

  task automatic rand_engine();
    err_i = 1'($urandom); vfail_i = 1'($urandom);
    cap_i = 16'($urandom); etype_i = $urandom; faddr_i = $urandom;
    ffname_i = 16'($urandom);
    exp_i = {$urandom, $urandom, $urandom, $urandom};
    got_i = {$urandom, $urandom, $urandom, $urandom};
    xfer_i = {8'($urandom), $urandom};
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [11:0] wr_offs [7];
    logic [11:0] rd_offs [21];
    logic [31:0] st;
    void'($urandom(32'h5EED_0042));
    wr_offs = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014, 12'h01C};
    rd_offs = '{12'h100, 12'h104, 12'h108, 12'h180, 12'h184, 12'h188, 12'h18C,
                12'h190, 12'h194, 12'h198, 12'h19C, 12'h1A0, 12'h1A4, 12'h1A8,
                12'h1AC, 12'h000, 12'h010, 12'h10C, 12'h1B0, 12'h102, 12'hFFC};
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; busy_i = 1'b0;
    rand_engine();
    m_fname = '0; m_count = '0; m_size = '0; m_pat = '0; m_stamp = '0;
    m_cmd = '0; m_trst = 1'b0;
    repeat (4) @(negedge clk);
    check_outs("R1 reset");
    chk("R1 rvalid", 64'(rvalid), 64'd0);
    chk("R1 rdata", 64'(rdata), 64'd0);
    chk("R1 start", 64'(start_o), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check_outs("R1 after release");
    chk("R1 rdata after release", 64'(rdata), 64'd0);

    // directed: masking of wide data
    wr("R2 name", 12'h000, 32'hDEAD_BEEF);
    wr("R2 count", 12'h004, 32'h1234_FFFF);
    wr("R2 size", 12'h008, 32'hFFFF_FFFD);
    wr("R2 pat", 12'h014, 32'h0000_00FC);
    // timestamp: year 43 month 7 day 3 hour 14 min 59 sec 29
    st = {7'd43, 4'd7, 5'd3, 5'd14, 6'd59, 5'd29};
    wr("R3 stamp", 12'h00C, st);
    // commands
    busy_i = 1'b0;
    wr("R4 cmd write", 12'h010, 32'hFFFF_FFF2);
    busy_i = 1'b1;
    wr("R5 cmd busy", 12'h010, 32'h0000_0003);
    busy_i = 1'b0;
    wr("R4 cmd read", 12'h010, 32'h0000_0003);
    wr("R4 cmd format", 12'h010, 32'h0000_0000);
    wr("R6 trst set", 12'h01C, 32'h0000_0001);
    wr("R6 trst clear", 12'h01C, 32'hFFFF_FFFE);
    // unmapped and read-only writes
    wr("R11 write 0x018", 12'h018, $urandom);
    wr("R11 write 0x100", 12'h100, $urandom);
    wr("R11 write 0x002", 12'h002, $urandom);
    wr("R11 write 0x0FC", 12'h0FC, $urandom);
    // reads of every offset
    busy_i = 1'b1; err_i = 1'b0; vfail_i = 1'b1;
    rd("R7 status", 12'h100);
    busy_i = 1'b0; err_i = 1'b1; vfail_i = 1'b0;
    rd("R7 status", 12'h100);
    rd("R8 capacity", 12'h104);
    rd("R8 error type", 12'h108);
    foreach (rd_offs[i]) begin
      rand_engine();
      if (i < 15) rd($sformatf("R9 read %0h", rd_offs[i]), rd_offs[i]);
      else rd($sformatf("R11 read %0h", rd_offs[i]), rd_offs[i]);
    end

    // constrained random mix
    for (int k = 0; k < 300; k++) begin
      int op;
      op = int'($urandom_range(0, 3));
      busy_i = 1'($urandom);
      rand_engine();
      if (op == 0) begin
        wr("R2 R4 R5 random write", wr_offs[$urandom_range(0, 6)], $urandom);
      end else if (op == 1) begin
        wr("R11 random stray write", {$urandom_range(32, 1023), 2'($urandom)}, $urandom);
      end else begin
        logic [11:0] a;
        a = rd_offs[$urandom_range(0, 20)];
        rd($sformatf("R7 R8 R9 R11 random read %0h", a), a);
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule